// File: doc/BRIEF.md
# Configuration Completion Receiver

This block waits for the completion that answers one outstanding configuration request. The request side arms it with a pulse, and the same pulse gives the access size and the byte lane of the request. The block then watches a 64-bit beat stream that carries a start flag and an end flag. The start beat carries a three-bit completion status in the high word. The end beat carries the returned dword in its low word. When the end beat arrives, the block checks the status and gives a single result: success with the read value shifted down and masked to the access size, device-not-found with an all-ones value, or timeout with an all-ones value if no end beat arrives inside the poll budget.

The result is held on the status and data outputs, and a one-cycle done pulse marks it. A new arm pulse always starts a fresh request. It discards any half-received packet and any status already captured.

Top module: `cpl_receiver`

## Requirements
- R1: After reset, done_o is 0, status_o is 2'b00 and rdata_o is 0.
- R2: Beats that arrive while the block is not armed are dropped: no done pulse follows them.
- R3: While armed, a beat is taken only if it has its start flag or its end flag set, or if a start beat was already taken in the current packet. A flagless beat before any start is ignored, and a flagless beat after a start has no effect on the result.
- R4: The completion status is taken from beat bits 47:45 (bits 15:13 of the high word) on a start beat. A beat that carries both flags uses its own status.
- R5: An end beat with a captured status of zero gives status_o 2'b00 (success), and the returned word comes from beat bits 31:0 of that end beat.
- R6: An end beat with a non-zero captured status gives status_o 2'b01 (device-not-found). Every non-success result has rdata_o equal to 32'hFFFFFFFF.
- R7: The captured status is 3'b111 when the block is armed, so an end beat with no start beat before it gives device-not-found.
- R8: If no end beat is taken within POLL_LIMIT polls of POLL_CYCLES cycles each, the result is status_o 2'b10 (timeout), due on the clock edge POLL_LIMIT*POLL_CYCLES edges after the arming edge. An end beat on that same edge takes priority and is reported instead.
- R9: Size code 2'b00 (one byte) returns (word >> 8*lane[1:0]) & 32'hFF.
- R10: Size code 2'b01 (two bytes) returns (word >> 16*lane[1]) & 32'hFFFF.
- R11: Size codes 2'b10 and 2'b11 (four bytes) return the full word.
- R12: done_o is high for exactly one cycle, on the edge that takes the end beat or on the edge where the timeout expires.
- R13: An arm pulse in the middle of a packet clears the started state and the captured status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Starts a new request wait |
| arm_size_i | input | 2 | Access size of the request: 00 byte, 01 half, 1x word |
| arm_lane_i | input | 2 | Low two address bits of the request |
| beat_valid_i | input | 1 | Beat present |
| beat_sop_i | input | 1 | Start-of-packet flag |
| beat_eop_i | input | 1 | End-of-packet flag |
| beat_data_i | input | 64 | Beat payload |
| done_o | output | 1 | One-cycle result strobe |
| status_o | output | 2 | 00 success, 01 device-not-found, 10 timeout |
| rdata_o | output | 32 | Aligned read value, all ones on failure |

## Verification
The success and not-found results are registered once. They appear right after the clock edge that samples the end beat, so the bench checks them at the falling edge that follows that beat and checks one cycle later that done has dropped. The timeout is due exactly POLL_LIMIT*POLL_CYCLES edges after the arming edge. The bench counts falling edges from the arm, checks that done is still low one edge early, and checks the timeout on the due edge. A separate case places an end beat on that same edge to check that the end beat wins.

// File: rtl/cpl_pkg.sv
package cpl_pkg;

    typedef enum logic [1:0] {
        CPL_OK      = 2'b00,
        CPL_ABSENT  = 2'b01,
        CPL_EXPIRED = 2'b10
    } cpl_res_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    localparam int STS_MSB = 47;
    localparam int STS_LSB = 45;
    localparam int STS_W   = STS_MSB - STS_LSB + 1;
    localparam logic [STS_W-1:0] STS_UNSEEN = '1;

    typedef struct packed {
        logic [1:0] size;
        logic [1:0] lane;
    } cpl_req_t;

    function automatic logic [31:0] lane_extract(logic [31:0] word, cpl_req_t req);
        logic [31:0] r;
        case (req.size)
            SZ_BYTE: r = (word >> (8 * req.lane)) & 32'h0000_00FF;
            SZ_HALF: r = (word >> (16 * req.lane[1])) & 32'h0000_FFFF;
            default: r = word;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpl_poll_timer.sv
module cpl_poll_timer #(
    parameter int POLL_CYCLES = 625,
    parameter int POLL_LIMIT  = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expire
);
    localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [CW-1:0] CYC_LAST  = CW'(POLL_CYCLES - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

    logic [CW-1:0] cyc_q;
    logic [PW-1:0] poll_q;
    logic          wrap;

    assign wrap   = (cyc_q == CYC_LAST);
    assign expire = run && wrap && (poll_q == POLL_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cyc_q  <= '0;
            poll_q <= '0;
        end else if (wrap) begin
            cyc_q  <= '0;
            poll_q <= (poll_q == POLL_LAST) ? '0 : poll_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    AST_POLL_RANGE: assert property (@(posedge clk) disable iff (rst)
        poll_q <= POLL_LAST) else $error("poll count out of range"); // R8

    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (rst)
        cyc_q <= CYC_LAST) else $error("cycle count out of range"); // R8

endmodule

// File: rtl/cpl_tracker.sv
module cpl_tracker
    import cpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  cpl_req_t          arm_req,
    input  logic              valid,
    input  logic              sop,
    input  logic              eop,
    input  logic [STS_W-1:0]  beat_sts,
    input  logic [31:0]       beat_word,
    input  logic              expire,
    output logic              armed,
    output logic              done,
    output cpl_res_e          res,
    output logic [31:0]       word,
    output cpl_req_t          req
);
    logic             armed_q, started_q, done_q;
    logic [STS_W-1:0] sts_q, sts_now;
    cpl_res_e         res_q;
    logic [31:0]      word_q;
    cpl_req_t         req_q;
    logic             take;

    assign take    = armed_q && valid && (sop || eop || started_q);
    assign sts_now = sop ? beat_sts : sts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            started_q <= 1'b0;
            sts_q     <= STS_UNSEEN;
            done_q    <= 1'b0;
            res_q     <= CPL_OK;
            word_q    <= '0;
            req_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (arm) begin
                armed_q   <= 1'b1;
                started_q <= 1'b0;
                sts_q     <= STS_UNSEEN;
                req_q     <= arm_req;
            end else if (take && eop) begin
                done_q    <= 1'b1;
                res_q     <= (sts_now == '0) ? CPL_OK : CPL_ABSENT;
                word_q    <= beat_word;
                armed_q   <= 1'b0;
                started_q <= 1'b0;
            end else if (take && sop) begin
                started_q <= 1'b1;
                sts_q     <= beat_sts;
            end else if (armed_q && expire) begin
                done_q  <= 1'b1;
                res_q   <= CPL_EXPIRED;
                armed_q <= 1'b0;
            end
        end
    end

    assign armed = armed_q;
    assign done  = done_q;
    assign res   = res_q;
    assign word  = word_q;
    assign req   = req_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q) else $error("done longer than one cycle"); // R12

    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !arm) |=> !done_q) else $error("result while idle"); // R2

    AST_BAD_STATUS: assert property (@(posedge clk) disable iff (rst)
        (take && eop && !arm && sts_now != '0) |=> (done_q && res_q == CPL_ABSENT))
        else $error("non-zero status not reported"); // R6

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        arm |=> (!started_q && sts_q == STS_UNSEEN)) else $error("arm left state"); // R13

endmodule

// File: rtl/cpl_lane_align.sv
module cpl_lane_align
    import cpl_pkg::*;
(
    input  cpl_res_e    res,
    input  logic [31:0] word,
    input  cpl_req_t    req,
    output logic [31:0] rdata
);
    always_comb begin
        if (res != CPL_OK) rdata = '1;
        else               rdata = lane_extract(word, req);
    end
endmodule

// File: rtl/cpl_receiver.sv
module cpl_receiver
    import cpl_pkg::*;
#(
    parameter int POLL_CYCLES = 625,
    parameter int POLL_LIMIT  = 500
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        arm_i,
    input  logic [1:0]  arm_size_i,
    input  logic [1:0]  arm_lane_i,
    input  logic        beat_valid_i,
    input  logic        beat_sop_i,
    input  logic        beat_eop_i,
    input  logic [63:0] beat_data_i,
    output logic        done_o,
    output logic [1:0]  status_o,
    output logic [31:0] rdata_o
);
    logic        armed, expire, done;
    cpl_res_e    res;
    logic [31:0] word;
    cpl_req_t    req, arm_req;
    logic        unused_bits;

    assign unused_bits = ^{beat_data_i[63:STS_MSB+1], beat_data_i[STS_LSB-1:32]};
    assign arm_req     = '{size: arm_size_i, lane: arm_lane_i};

    cpl_poll_timer #(
        .POLL_CYCLES (POLL_CYCLES),
        .POLL_LIMIT  (POLL_LIMIT)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (arm_i),
        .run    (armed),
        .expire (expire)
    );

    cpl_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm_i),
        .arm_req   (arm_req),
        .valid     (beat_valid_i),
        .sop       (beat_sop_i),
        .eop       (beat_eop_i),
        .beat_sts  (beat_data_i[STS_MSB:STS_LSB]),
        .beat_word (beat_data_i[31:0]),
        .expire    (expire),
        .armed     (armed),
        .done      (done),
        .res       (res),
        .word      (word),
        .req       (req)
    );

    cpl_lane_align u_align (
        .res   (res),
        .word  (word),
        .req   (req),
        .rdata (rdata_o)
    );

    assign done_o   = done;
    assign status_o = res;

    AST_FAIL_ONES: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o != CPL_OK) |-> rdata_o == 32'hFFFF_FFFF)
        else $error("failure value not all ones"); // R6

    AST_BYTE_NARROW: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o == CPL_OK && req.size == SZ_BYTE) |-> rdata_o[31:8] == '0)
        else $error("byte read too wide"); // R9

    AST_HALF_NARROW: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o == CPL_OK && req.size == SZ_HALF) |-> rdata_o[31:16] == '0)
        else $error("half read too wide"); // R10

    AST_TIMEOUT_ONLY_ARMED: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o == CPL_EXPIRED) |-> $past(armed))
        else $error("timeout without wait"); // R8

endmodule

// File: tb/tb_cpl_receiver.sv
module tb_cpl_receiver;
    localparam int PC = 4;
    localparam int PL = 500;
    localparam int TO = PC * PL;
    localparam logic [31:0] D = 32'hA1B2_C3D4;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm_i = 1'b0;
    logic [1:0]  arm_size_i = '0;
    logic [1:0]  arm_lane_i = '0;
    logic        beat_valid_i = 1'b0;
    logic        beat_sop_i = 1'b0;
    logic        beat_eop_i = 1'b0;
    logic [63:0] beat_data_i = '0;
    logic        done_o;
    logic [1:0]  status_o;
    logic [31:0] rdata_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    cpl_receiver #(.POLL_CYCLES(PC), .POLL_LIMIT(PL)) dut (
        .clk(clk), .rst(rst), .arm_i(arm_i), .arm_size_i(arm_size_i),
        .arm_lane_i(arm_lane_i), .beat_valid_i(beat_valid_i),
        .beat_sop_i(beat_sop_i), .beat_eop_i(beat_eop_i),
        .beat_data_i(beat_data_i), .done_o(done_o), .status_o(status_o),
        .rdata_o(rdata_o)
    );

    // vector: size, lane, cpl status, expected status, expected data
    typedef logic [2+2+3+2+32-1:0] vec_t;
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        {2'b10, 2'd0, 3'd0, 2'b00, D},
        {2'b00, 2'd0, 3'd0, 2'b00, 32'h0000_00D4},
        {2'b00, 2'd3, 3'd0, 2'b00, 32'h0000_00A1},
        {2'b00, 2'd1, 3'd0, 2'b00, 32'h0000_00C3},
        {2'b01, 2'd0, 3'd0, 2'b00, 32'h0000_C3D4},
        {2'b01, 2'd2, 3'd0, 2'b00, 32'h0000_A1B2},
        {2'b01, 2'd3, 3'd0, 2'b00, 32'h0000_A1B2},
        {2'b10, 2'd0, 3'd1, 2'b01, ONES},
        {2'b00, 2'd2, 3'd4, 2'b01, ONES},
        {2'b11, 2'd1, 3'd0, 2'b00, D}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_arm(logic [1:0] sz, logic [1:0] ln);
        arm_i = 1'b1; arm_size_i = sz; arm_lane_i = ln;
        @(negedge clk);
        arm_i = 1'b0;
    endtask

    task automatic beat(logic s, logic e, logic [2:0] sts, logic [31:0] lo);
        beat_valid_i = 1'b1; beat_sop_i = s; beat_eop_i = e;
        beat_data_i = {16'h0, sts, 13'h0, lo};
        @(negedge clk);
        beat_valid_i = 1'b0; beat_sop_i = 1'b0; beat_eop_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 done", {31'h0, done_o}, 32'h0);
        check("R1 status", {30'h0, status_o}, 32'h0);
        check("R1 rdata", rdata_o, 32'h0);

        // R2: idle beats dropped
        beat(1'b1, 1'b1, 3'd0, D);
        check("R2 idle eop no done", {31'h0, done_o}, 32'h0);

        // vector table: R4 R5 R6 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            logic [1:0] sz, ln, es;
            logic [2:0] st;
            logic [31:0] ed;
            string tag;
            {sz, ln, st, es, ed} = VECS[i];
            tag = (es != 2'b00) ? "R6" : (sz == 2'b00) ? "R9" :
                  (sz == 2'b01) ? "R10" : "R11";
            do_arm(sz, ln);
            beat(1'b1, 1'b0, st, 32'h0BAD_0000);
            beat(1'b0, 1'b0, 3'd7, 32'h0BAD_0001);
            beat(1'b0, 1'b1, 3'd7, D);
            check({tag, " R12 done"}, {31'h0, done_o}, 32'h1);
            check({tag, " R4 status"}, {30'h0, status_o}, {30'h0, es});
            check({tag, " R5 data"}, rdata_o, ed);
            @(negedge clk);
            check("R12 done drops", {31'h0, done_o}, 32'h0);
        end

        // R3: flagless beat before start ignored; single beat uses own status
        do_arm(2'b10, 2'd0);
        beat(1'b0, 1'b0, 3'd0, 32'h1111_1111);
        check("R3 flagless no done", {31'h0, done_o}, 32'h0);
        beat(1'b1, 1'b1, 3'd0, 32'h2222_2222);
        check("R3 R4 single beat status", {30'h0, status_o}, 32'h0);
        check("R3 single beat data", rdata_o, 32'h2222_2222);

        // R7: end without start
        do_arm(2'b10, 2'd0);
        beat(1'b0, 1'b1, 3'd0, D);
        check("R7 done", {31'h0, done_o}, 32'h1);
        check("R7 status", {30'h0, status_o}, 32'h1);
        check("R7 rdata", rdata_o, ONES);

        // R13: re-arm mid packet clears captured status
        do_arm(2'b10, 2'd0);
        beat(1'b1, 1'b0, 3'd0, 32'h0);
        do_arm(2'b10, 2'd0);
        beat(1'b0, 1'b1, 3'd0, D);
        check("R13 status", {30'h0, status_o}, 32'h1);
        check("R13 rdata", rdata_o, ONES);

        // R8: timeout
        do_arm(2'b10, 2'd0);
        repeat (TO - 1) @(negedge clk);
        check("R8 no early timeout", {31'h0, done_o}, 32'h0);
        @(negedge clk);
        check("R8 timeout done", {31'h0, done_o}, 32'h1);
        check("R8 timeout status", {30'h0, status_o}, 32'h2);
        check("R8 timeout rdata", rdata_o, ONES);
        @(negedge clk);
        check("R12 timeout done drops", {31'h0, done_o}, 32'h0);

        // R8: end beat on expiry edge wins
        do_arm(2'b10, 2'd0);
        repeat (TO - 1) @(negedge clk);
        beat(1'b1, 1'b1, 3'd0, D);
        check("R8 late end status", {30'h0, status_o}, 32'h0);
        check("R8 late end data", rdata_o, D);
        @(negedge clk);
        check("R8 no second done", {31'h0, done_o}, 32'h0);

        finish_run();
    end
endmodule